// File: doc/BRIEF.md
# Four-Channel Cycle-Stealing DMA Controller

This block moves data between peripherals and memory without the processor copying each word. There are four channels, and each channel is owned by one peripheral. Software programs a channel through a small register port. It writes a memory start address, a word count and a direction, and then sets the channel's enable bit. From then on, the peripheral raises its request line whenever it has a word ready or wants one.

For each word, the controller asks the processor for the bus and waits for the grant. It then drives the memory address and gives a single read or write strobe, with an acknowledge pulse to the serving peripheral in the same cycle. After that it hands the bus back. The processor is only paused for the borrowed cycle and keeps its own context.

When several channels ask at once, the lowest-numbered channel wins, and the choice is made again before every word. When a channel's count runs out, the channel switches itself off and raises a completion flag. The interrupt line stays high until software clears every raised flag.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset, hold_req, mem_rd, mem_wr, dack and irq are low, and every channel's address, count and control registers read back as zero.
- R2: reg_addr is {channel[1:0], select[1:0]}. Select 0 is the address register, 1 is the count register and 2 is the control register (bit 0 enable, bit 1 direction). A write stores the value and a read returns it on reg_rdata in the same cycle.
- R3: Writing enable=1 while the channel's count is zero leaves enable at 0, and that channel's request never causes hold_req.
- R4: A pending request raises hold_req on the next clock. The strobe comes in the cycle after hold_ack is first seen high and lasts exactly one cycle. hold_req falls on the clock after the strobe and does not rise again before hold_ack has been seen low.
- R5: Direction 1 produces mem_wr (peripheral to memory) and direction 0 produces mem_rd. dack is one-hot on the served channel and is high only in the strobe cycle.
- R6: Among enabled channels with dreq high, the lowest index is served. The choice is made again before every word.
- R7: During the strobe, mem_addr equals the channel's current address. After each word the address goes up by one, wrapping from 0xFFFF to 0x0000, and the count goes down by one.
- R8: When a word brings the count to zero, the channel's enable reads back 0, its done flag is set, and it serves no further words.
- R9: Select 3 is the status register. Bits [3:0] are the done flags and bits [7:4] are the enables. Writing it clears each done flag whose data bit is 1 and leaves the others. irq is high exactly while any done flag is set.
- R10: dreq on a channel whose enable is 0 causes no bus request and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel and register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| dreq | input | 4 | Peripheral service requests |
| dack | output | 4 | Peripheral acknowledge, strobe cycle only |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | 16 | Memory address during the strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench builds the block with its defaults: four channels and 16-bit address and count. With those values, a start address of 0xFFFF followed by two words exercises the address wrap. Short counts of one to three words reach the exhaustion path on every channel in a few dozen cycles. Two simultaneous requesters, plus a higher-priority request raised part-way through a lower channel's block, show that priority is decided again for each word. A grant held back for several cycles confirms that no strobe leaks out before the bus is granted.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_XFER = 2'd2,
      ST_REL  = 2'd3
   } bus_st_e;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_CNT  = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_DIR_BIT = 1;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              wr_ctrl,
   input  logic [REG_W-1:0]  wdata,
   input  logic              clr_done,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              en_q,
   output logic              dir_q,
   output logic              done_q
);
   import dma_steal_pkg::*;

   logic last_word;
   assign last_word = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         en_q   <= 1'b0;
         dir_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (step) begin
            addr_q <= addr_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
            if (last_word) begin
               en_q   <= 1'b0;
               done_q <= 1'b1;
            end
         end
         if (wr_addr) addr_q <= wdata[ADDR_W-1:0];
         if (wr_cnt)  cnt_q  <= wdata[CNT_W-1:0];
         if (wr_ctrl) begin
            en_q  <= wdata[CTRL_EN_BIT] && (cnt_q != '0);
            dir_q <= wdata[CTRL_DIR_BIT];
         end
         if (clr_done) done_q <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   assign any = |req;

   generate
      if (N == 1) begin : g_single
         assign idx = '0;
      end else begin : g_multi
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm #(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_req,
   input  logic [IDX_W-1:0] pick_idx,
   input  logic             hold_ack,
   output logic             hold_req,
   output logic             xfer,
   output logic [IDX_W-1:0] cur_idx
);
   import dma_steal_pkg::*;

   bus_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (any_req)   st_d = ST_HOLD;
         ST_HOLD: if (hold_ack)  st_d = ST_XFER;
         ST_XFER:                st_d = ST_REL;
         ST_REL:  if (!hold_ack) st_d = ST_IDLE;
         default:                st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cur_idx <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && any_req) cur_idx <= pick_idx;
      end
   end

   assign hold_req = (st_q == ST_HOLD) || (st_q == ST_XFER);
   assign xfer     = (st_q == ST_XFER);

endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)+1:0] reg_addr,
   input  logic [((ADDR_W > CNT_W) ? ADDR_W : CNT_W)-1:0] reg_wdata,
   output logic [((ADDR_W > CNT_W) ? ADDR_W : CNT_W)-1:0] reg_rdata,
   input  logic [NUM_CH-1:0]     dreq,
   output logic [NUM_CH-1:0]     dack,
   output logic                  hold_req,
   input  logic                  hold_ack,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic                  mem_rd,
   output logic                  mem_wr,
   output logic                  irq
);
   import dma_steal_pkg::*;

   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("NUM_CH must lie in 1..8");
   end
   if (ADDR_W < 2 || CNT_W < 2) begin : g_bad_w
      $error("ADDR_W and CNT_W must be at least 2");
   end
   if (2 * NUM_CH > REG_W) begin : g_bad_stat
      $error("status register needs 2*NUM_CH bits");
   end

   reg_sel_e        sel;
   logic [CH_W-1:0] rch;
   assign sel = reg_sel_e'(reg_addr[1:0]);
   assign rch = reg_addr[CH_W+1:2];

   logic [ADDR_W-1:0] ch_addr [NUM_CH];
   logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
   logic [NUM_CH-1:0] ch_en, ch_dir, ch_done;

   logic            xfer, any_req;
   logic [CH_W-1:0] pick_idx, cur_idx;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = reg_wr && (rch == CH_W'(i));
      dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_addr  (hit && sel == SEL_ADDR),
         .wr_cnt   (hit && sel == SEL_CNT),
         .wr_ctrl  (hit && sel == SEL_CTRL),
         .wdata    (reg_wdata),
         .clr_done (reg_wr && sel == SEL_STAT && reg_wdata[i]),
         .step     (xfer && cur_idx == CH_W'(i)),
         .addr_q   (ch_addr[i]),
         .cnt_q    (ch_cnt[i]),
         .en_q     (ch_en[i]),
         .dir_q    (ch_dir[i]),
         .done_q   (ch_done[i])
      );
   end

   dma_prio_pick #(.N(NUM_CH), .IDX_W(CH_W)) u_pick (
      .req (dreq & ch_en),
      .any (any_req),
      .idx (pick_idx)
   );

   dma_bus_fsm #(.IDX_W(CH_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_req  (any_req),
      .pick_idx (pick_idx),
      .hold_ack (hold_ack),
      .hold_req (hold_req),
      .xfer     (xfer),
      .cur_idx  (cur_idx)
   );

   assign dack     = xfer ? (NUM_CH'(1) << cur_idx) : '0;
   assign mem_rd   = xfer && !ch_dir[cur_idx];
   assign mem_wr   = xfer &&  ch_dir[cur_idx];
   assign mem_addr = xfer ? ch_addr[cur_idx] : '0;
   assign irq      = |ch_done;

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_ADDR: reg_rdata[ADDR_W-1:0] = ch_addr[rch];
         SEL_CNT:  reg_rdata[CNT_W-1:0]  = ch_cnt[rch];
         SEL_CTRL: begin
            reg_rdata[CTRL_EN_BIT]  = ch_en[rch];
            reg_rdata[CTRL_DIR_BIT] = ch_dir[rch];
         end
         default: begin
            reg_rdata[NUM_CH-1:0]        = ch_done;
            reg_rdata[2*NUM_CH-1:NUM_CH] = ch_en;
         end
      endcase
   end

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              hold_req,
   input logic              hold_ack,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [NUM_CH-1:0] dack,
   input logic              irq
);

   logic strobe;
   assign strobe = mem_rd || mem_wr;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R5
   AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack)); // R5
   AST_DACK_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) == strobe); // R5
   AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (hold_req && hold_ack)); // R4
   AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe); // R4
   AST_RELEASE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !hold_req); // R4
   AST_NO_EARLY_REHOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_req && hold_ack) |=> !hold_req); // R4
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_wr) |=> irq); // R9

endmodule

bind dma_steal_ctrl dma_steal_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .hold_req (hold_req),
   .hold_ack (hold_ack),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .dack     (dack),
   .irq      (irq)
);

// File: tb/sim_dma_steal_ctrl.sv
module sim_dma_steal_ctrl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  dreq = '0;
   logic [3:0]  dack;
   logic        hold_req;
   logic        hold_ack = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, irq;

   int total = 0;
   int fails = 0;
   bit ack_auto = 1'b1;
   bit ack_force = 1'b0;
   bit cmp_on = 1'b0;
   int xlog[$];

   // reference state
   int m_addr [4];
   int m_cnt  [4];
   bit m_en   [4];
   bit m_dir  [4];
   bit m_done [4];
   int m_st;
   int m_cur;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_steal_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
      .hold_req(hold_req), .hold_ack(hold_ack), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_addr[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_dir[i] = 0; m_done[i] = 0;
         end
         m_st = 0; m_cur = 0;
      end else begin
         int ch;
         int sel;
         int old_cnt;
         ch = reg_addr / 4;
         sel = reg_addr % 4;
         old_cnt = m_cnt[ch];
         case (m_st)
            0: begin
               for (int i = 3; i >= 0; i--)
                  if (dreq[i] && m_en[i]) begin m_cur = i; m_st = 1; end
            end
            1: if (hold_ack) m_st = 2;
            2: begin
               m_addr[m_cur] = (m_addr[m_cur] + 1) % 65536;
               m_cnt[m_cur] = m_cnt[m_cur] - 1;
               if (m_cnt[m_cur] == 0) begin m_en[m_cur] = 0; m_done[m_cur] = 1; end
               m_st = 3;
            end
            default: if (!hold_ack) m_st = 0;
         endcase
         if (reg_wr) begin
            case (sel)
               0: m_addr[ch] = reg_wdata;
               1: m_cnt[ch] = reg_wdata;
               2: begin m_en[ch] = reg_wdata[0] && (old_cnt != 0); m_dir[ch] = reg_wdata[1]; end
               default: for (int i = 0; i < 4; i++) if (reg_wdata[i]) m_done[i] = 0;
            endcase
         end
      end
   end

   // grant responder
   always @(negedge clk) hold_ack <= ack_auto ? hold_req : ack_force;

   // per-cycle comparison and strobe log
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         bit xf;
         int exp_irq;
         xf = (m_st == 2);
         exp_irq = 0;
         for (int i = 0; i < 4; i++) if (m_done[i]) exp_irq = 1;
         check("R4 hold_req", int'(hold_req), int'(m_st == 1 || m_st == 2));
         check("R5 mem_rd", int'(mem_rd), int'(xf && !m_dir[m_cur]));
         check("R5 mem_wr", int'(mem_wr), int'(xf && m_dir[m_cur]));
         check("R6 dack", int'(dack), xf ? (1 << m_cur) : 0);
         check("R7 mem_addr", int'(mem_addr), xf ? m_addr[m_cur] : 0);
         check("R9 irq", int'(irq), exp_irq);
      end
      if (mem_rd || mem_wr) begin
         for (int i = 0; i < 4; i++) if (dack[i]) xlog.push_back(i * 2 + int'(mem_wr));
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   task automatic wr(input int ch, input int sel, input int val);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(ch * 4 + sel); reg_wdata = 16'(val);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int ch, input int sel, input int exp, input string req);
      @(negedge clk);
      reg_addr = 4'(ch * 4 + sel);
      #1;
      check(req, int'(reg_rdata), exp);
   endtask

   task automatic wait_log(input int n);
      for (int k = 0; k < 200 && xlog.size() < n; k++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1 hold_req", int'(hold_req), 0);
      check("R1 strobes", int'(mem_rd | mem_wr), 0);
      check("R1 dack", int'(dack), 0);
      check("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      rd(2, 0, 0, "R1 addr");
      rd(2, 1, 0, "R1 count");
      rd(2, 2, 0, "R1 ctrl");

      // R2 programming channel 1
      wr(1, 0, 16'h1000);
      wr(1, 1, 3);
      wr(1, 2, 3);
      rd(1, 0, 16'h1000, "R2 addr");
      rd(1, 1, 3, "R2 count");
      rd(1, 2, 3, "R2 ctrl");

      // R3 enable with zero count
      wr(2, 2, 1);
      rd(2, 2, 0, "R3 enable refused");
      dreq = 4'b0100;
      repeat (6) @(negedge clk);
      check("R3 no hold", int'(hold_req), 0);

      // three words on channel 1, write direction
      dreq = 4'b0110;
      wait_log(3);
      repeat (6) @(negedge clk);
      check("R5 words", xlog.size(), 3);
      foreach (xlog[i]) check("R5 write channel 1", xlog[i], 3);
      rd(1, 0, 16'h1003, "R7 address advanced");
      rd(1, 1, 0, "R7 count spent");
      rd(1, 2, 2, "R8 enable cleared");
      rd(0, 3, 16'h0002, "R8 done flag");
      check("R9 irq raised", int'(irq), 1);
      // R10 disabled channel keeps requesting
      repeat (10) @(negedge clk);
      check("R10 no extra word", xlog.size(), 3);
      check("R10 no hold", int'(hold_req), 0);

      // R9 status clear
      wr(0, 3, 16'h0001);
      check("R9 irq kept", int'(irq), 1);
      wr(3, 3, 16'h0002);
      check("R9 irq cleared", int'(irq), 0);

      // R6 simultaneous requests, R7 wrap
      dreq = 4'b0000;
      xlog.delete();
      wr(3, 0, 16'h0020); wr(3, 1, 2); wr(3, 2, 3);
      wr(0, 0, 16'hFFFF); wr(0, 1, 2); wr(0, 2, 1);
      dreq = 4'b1001;
      wait_log(4);
      repeat (6) @(negedge clk);
      check("R6 order size", xlog.size(), 4);
      if (xlog.size() == 4) begin
         check("R6 first ch0", xlog[0], 0);
         check("R6 second ch0", xlog[1], 0);
         check("R6 third ch3", xlog[2], 7);
         check("R6 fourth ch3", xlog[3], 7);
      end
      rd(0, 0, 16'h0001, "R7 wrap");
      rd(0, 3, 16'h0009, "R8 done pair");
      wr(0, 3, 16'h000F);

      // R6 re-decision between words
      dreq = 4'b0000;
      xlog.delete();
      wr(3, 1, 3); wr(3, 2, 3);
      wr(0, 1, 1); wr(0, 2, 3);
      dreq = 4'b1000;
      wait_log(1);
      dreq = 4'b1001;
      wait_log(4);
      repeat (6) @(negedge clk);
      check("R6 resched size", xlog.size(), 4);
      if (xlog.size() == 4) begin
         check("R6 resched w0", xlog[0], 7);
         check("R6 resched w1", xlog[1], 1);
         check("R6 resched w2", xlog[2], 7);
         check("R6 resched w3", xlog[3], 7);
      end
      wr(0, 3, 16'h000F);

      // R4 delayed grant
      dreq = 4'b0000;
      xlog.delete();
      ack_force = 1'b0;
      ack_auto = 1'b0;
      wr(2, 0, 16'h0040); wr(2, 1, 1); wr(2, 2, 1);
      dreq = 4'b0100;
      repeat (6) @(negedge clk);
      check("R4 waiting for grant", int'(hold_req), 1);
      check("R4 no strobe before grant", xlog.size(), 0);
      ack_force = 1'b1;
      repeat (3) @(negedge clk);
      check("R4 one word after grant", xlog.size(), 1);
      ack_force = 1'b0;
      repeat (3) @(negedge clk);
      ack_auto = 1'b1;
      repeat (4) @(negedge clk);
      check("R4 released", int'(hold_req), 0);
      summary();
   end

endmodule